// File: doc/BRIEF.md
# Quad DAC Serial Command Decoder

This block is the digital front end of a four-channel digital-to-analog converter. A host sends 24-bit frames over a three-wire serial link made of a serial clock, an active-low frame select and a data line. The block samples these pins with its own system clock, takes one data bit on each falling edge of the serial clock while the select is low, and acts on a frame only when the twenty-fourth bit arrives. Each channel has a buffered input register and a live output (DAC) register, so a host can stage new codes and then move them to the outputs together.

A frame carries, from the most significant end: two bits that are ignored, a 3-bit command, a 3-bit channel address and a 16-bit code. Commands cover staged writes, updates, writes with immediate update, a write that also updates every channel, a per-channel power-down setting, a full register reset and a per-channel mask for a hardware load strobe. A frame whose select is released early is thrown away with no effect.

Top module: `quad_dac_cmd_dec`

## Requirements
- R1: While reset is asserted, and right after it, every DAC code, the power-down field, the power-down flags and the load mask are zero.
- R2: A frame is sent MSB first on falling serial-clock edges; bits 21..19 are the command, bits 18..16 the address and bits 15..0 the code; bits 23..22 have no effect. Command 3'b011 loads the code into both registers of the addressed channel, and the DAC output changes only after the 24th edge.
- R3: Command 3'b000 writes only the input register of the addressed channel; the DAC output is unchanged until command 3'b001 copies that input register into the DAC register.
- R4: Command 3'b010 writes the addressed input register and then copies every channel's input register into its DAC register.
- R5: Addresses 3'b000..3'b011 select channels 0..3 (channel n at dac_code[16n+15:16n]); address 3'b111 selects all four; addresses 3'b100..3'b110 select no channel.
- R6: Releasing the select before the 24th falling edge discards the frame: no register changes, and the next full frame is decoded normally.
- R7: Falling edges after the 24th, with the select still low, are ignored until the select goes high and low again.
- R8: Command 3'b100 loads code bits 7..0 into pd_mode, two bits per channel (channel n in bits 2n+1..2n); pd_active[n] is 1 when that pair is non-zero. The address is not used.
- R9: Command 3'b101 returns all input, DAC, power-down and mask registers to zero.
- R10: Command 3'b110 loads code bits 3..0 into ldac_mask; a falling edge on ldac_n copies the input register into the DAC register of each channel whose mask bit is 0.
- R11: Command 3'b111 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, bits taken on its falling edge |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Active-low hardware load strobe |
| dac_code | output | 64 | Four 16-bit DAC register values, channel 0 in the low bits |
| pd_mode | output | 8 | Power-down mode, two bits per channel |
| pd_active | output | 4 | Per-channel powered-down flag |
| ldac_mask | output | 4 | Load-strobe mask, 1 blocks the strobe for that channel |

## Verification
The decoder is driven with directed frames for each command and with a long run of random frames whose command, address, code and length are drawn at random, interleaved with load strobes. Frames cut short at random lengths separate a decoder that commits only on the 24th edge from one that commits on any partial count, and frames padded with extra bits show whether the bit counter stops after a full frame. Reserved and unused addresses tell apart a decoder that defaults to some channel from one that selects none, and staged writes followed by masked strobes show whether the input and DAC registers are kept apart per channel.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int CH_N    = 4;
  localparam int CODE_W  = 16;
  localparam int FRAME_W = 24;
  localparam int PAY_W   = FRAME_W - 2;
  localparam int PD_W    = 2;
  localparam int PD_BITS = CH_N * PD_W;
  localparam int ADR_W   = 3;

  typedef enum logic [2:0] {
    OP_WR_IN      = 3'b000,
    OP_UPD        = 3'b001,
    OP_WR_UPD_ALL = 3'b010,
    OP_WR_UPD     = 3'b011,
    OP_PWR        = 3'b100,
    OP_RST        = 3'b101,
    OP_MASK       = 3'b110,
    OP_NOP        = 3'b111
  } op_e;

  localparam logic [ADR_W-1:0] ADR_ALL = 3'b111;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int             STAGES  = 2,
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx
  import qdac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             sel_n_s,
  input  logic             din_s,
  output logic             frm_valid,
  output logic [PAY_W-1:0] frm_word
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic             sclk_q;
  logic [PAY_W-2:0] shift_q, shift_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             valid_q, valid_d;
  logic [PAY_W-1:0] word_q, word_d;
  logic             sclk_fall;

  assign sclk_fall = sclk_q & ~sclk_s;

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    valid_d = 1'b0;
    word_d  = word_q;
    if (sel_n_s) begin
      shift_d = '0;
      cnt_d   = '0;
      done_d  = 1'b0;
    end else if (sclk_fall && !done_q) begin
      shift_d = {shift_q[PAY_W-3:0], din_s};
      if (cnt_q == LAST) begin
        valid_d = 1'b1;
        word_d  = {shift_q, din_s};
        done_d  = 1'b1;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b1;
      shift_q <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      sclk_q  <= sclk_s;
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      valid_q <= valid_d;
      if (valid_d) word_q <= word_d;
    end
  end

  assign frm_valid = valid_q;
  assign frm_word  = word_q;
endmodule

// File: rtl/qdac_reg_bank.sv
module qdac_reg_bank
  import qdac_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frm_valid,
  input  logic [PAY_W-1:0]             frm_word,
  input  logic                         ldac_fall,
  output logic [CH_N-1:0][CODE_W-1:0]  dac_q,
  output logic [PD_BITS-1:0]           pd_q,
  output logic [CH_N-1:0]              mask_q
);
  logic [CH_N-1:0][CODE_W-1:0] inp_q, inp_d, dac_d;
  logic [PD_BITS-1:0]          pd_d;
  logic [CH_N-1:0]             mask_d;
  logic [CH_N-1:0]             sel;
  logic                        upd_en;
  op_e                         op;
  logic [ADR_W-1:0]            adr;
  logic [CODE_W-1:0]           code;

  assign op     = op_e'(frm_word[PAY_W-1 -: 3]);
  assign adr    = frm_word[CODE_W +: ADR_W];
  assign code   = frm_word[CODE_W-1:0];
  assign upd_en = frm_valid | ldac_fall;

  always_comb begin
    for (int i = 0; i < CH_N; i++) begin
      sel[i] = (adr == ADR_ALL) || (adr == ADR_W'(i));
    end
  end

  always_comb begin
    inp_d  = inp_q;
    dac_d  = dac_q;
    pd_d   = pd_q;
    mask_d = mask_q;
    if (ldac_fall) begin
      for (int i = 0; i < CH_N; i++) begin
        if (!mask_q[i]) dac_d[i] = inp_q[i];
      end
    end
    if (frm_valid) begin
      case (op)
        OP_WR_IN: begin
          for (int i = 0; i < CH_N; i++) if (sel[i]) inp_d[i] = code;
        end
        OP_UPD: begin
          for (int i = 0; i < CH_N; i++) if (sel[i]) dac_d[i] = inp_q[i];
        end
        OP_WR_UPD_ALL: begin
          for (int i = 0; i < CH_N; i++) begin
            if (sel[i]) inp_d[i] = code;
            dac_d[i] = sel[i] ? code : inp_q[i];
          end
        end
        OP_WR_UPD: begin
          for (int i = 0; i < CH_N; i++) begin
            if (sel[i]) begin
              inp_d[i] = code;
              dac_d[i] = code;
            end
          end
        end
        OP_PWR:  pd_d   = code[PD_BITS-1:0];
        OP_RST: begin
          inp_d  = '0;
          dac_d  = '0;
          pd_d   = '0;
          mask_d = '0;
        end
        OP_MASK: mask_d = code[CH_N-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inp_q  <= '0;
      dac_q  <= '0;
      pd_q   <= '0;
      mask_q <= '0;
    end else if (upd_en) begin
      inp_q  <= inp_d;
      dac_q  <= dac_d;
      pd_q   <= pd_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/quad_dac_cmd_dec.sv
module quad_dac_cmd_dec
  import qdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ser_clk,
  input  logic                      ser_sel_n,
  input  logic                      ser_din,
  input  logic                      ldac_n,
  output logic [CH_N*CODE_W-1:0]    dac_code,
  output logic [PD_BITS-1:0]        pd_mode,
  output logic [CH_N-1:0]           pd_active,
  output logic [CH_N-1:0]           ldac_mask
);
  logic [3:0]                  pins_s;
  logic                        sclk_s, sel_n_s, din_s, ldac_s;
  logic                        ldac_q;
  logic                        ldac_fall;
  logic                        frm_valid;
  logic [PAY_W-1:0]            frm_word;
  logic [CH_N-1:0][CODE_W-1:0] dac_q;

  qdac_sync #(
    .STAGES  (SYNC_STAGES),
    .W       (4),
    .RST_VAL (4'b1110)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ldac_n, ser_clk, ser_sel_n, ser_din}),
    .q     (pins_s)
  );

  assign {ldac_s, sclk_s, sel_n_s, din_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ldac_q <= 1'b1;
    else        ldac_q <= ldac_s;
  end

  assign ldac_fall = ldac_q & ~ldac_s;

  qdac_frame_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (sclk_s),
    .sel_n_s   (sel_n_s),
    .din_s     (din_s),
    .frm_valid (frm_valid),
    .frm_word  (frm_word)
  );

  qdac_reg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_valid (frm_valid),
    .frm_word  (frm_word),
    .ldac_fall (ldac_fall),
    .dac_q     (dac_q),
    .pd_q      (pd_mode),
    .mask_q    (ldac_mask)
  );

  assign dac_code = dac_q;

  for (genvar c = 0; c < CH_N; c++) begin : g_pd
    assign pd_active[c] = |pd_mode[c*PD_W +: PD_W];
  end
endmodule

// File: rtl/qdac_chk.sv
module qdac_chk
  import qdac_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   frm_valid,
  input logic [PAY_W-1:0]       frm_word,
  input logic                   ldac_fall,
  input logic [CH_N*CODE_W-1:0] dac_code,
  input logic [PD_BITS-1:0]     pd_mode,
  input logic [CH_N-1:0]        ldac_mask
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_zero_R1: assert (dac_code == '0 && pd_mode == '0 && ldac_mask == '0);
    end
  end

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_valid && !ldac_fall) |=> ($stable(dac_code) && $stable(pd_mode) && $stable(ldac_mask)));

  assert_one_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid);

  assert_pd_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_word[PAY_W-1 -: 3] == 3'b100) |=> (pd_mode == $past(frm_word[PD_BITS-1:0])));

  assert_mask_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_word[PAY_W-1 -: 3] == 3'b110) |=> (ldac_mask == $past(frm_word[CH_N-1:0])));

  assert_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_word[PAY_W-1 -: 3] == 3'b111 && !ldac_fall)
      |=> ($stable(dac_code) && $stable(pd_mode) && $stable(ldac_mask)));

  assert_reset_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_word[PAY_W-1 -: 3] == 3'b101) |=> (dac_code == '0 && pd_mode == '0 && ldac_mask == '0));
endmodule

bind quad_dac_cmd_dec qdac_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_valid (frm_valid),
  .frm_word  (frm_word),
  .ldac_fall (ldac_fall),
  .dac_code  (dac_code),
  .pd_mode   (pd_mode),
  .ldac_mask (ldac_mask)
);

// File: tb/quad_dac_cmd_dec_tb.sv
module quad_dac_cmd_dec_tb;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        ser_clk = 1'b1;
  logic        ser_sel_n = 1'b1;
  logic        ser_din = 1'b0;
  logic        ldac_n = 1'b1;
  logic [63:0] dac_code;
  logic [7:0]  pd_mode;
  logic [3:0]  pd_active;
  logic [3:0]  ldac_mask;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] m_in [4];
  logic [15:0] m_dac [4];
  logic [7:0]  m_pd;
  logic [3:0]  m_mask;

  always #2.5 clk = ~clk;

  quad_dac_cmd_dec u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_clk   (ser_clk),
    .ser_sel_n (ser_sel_n),
    .ser_din   (ser_din),
    .ldac_n    (ldac_n),
    .dac_code  (dac_code),
    .pd_mode   (pd_mode),
    .pd_active (pd_active),
    .ldac_mask (ldac_mask)
  );

  function automatic logic [63:0] exp_dac();
    return {m_dac[3], m_dac[2], m_dac[1], m_dac[0]};
  endfunction

  function automatic logic [3:0] exp_act();
    logic [3:0] a;
    for (int i = 0; i < 4; i++) a[i] = (m_pd[2*i +: 2] != 2'b00);
    return a;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin
      m_in[i] = '0;
      m_dac[i] = '0;
    end
    m_pd = '0;
    m_mask = '0;
  endtask

  task automatic model_frame(input logic [23:0] w);
    logic [2:0]  cmd;
    logic [2:0]  adr;
    logic [15:0] code;
    logic [3:0]  s;
    cmd = w[21:19];
    adr = w[18:16];
    code = w[15:0];
    for (int i = 0; i < 4; i++) s[i] = (adr == 3'd7) || (adr == 3'(i));
    case (cmd)
      3'b000: for (int i = 0; i < 4; i++) if (s[i]) m_in[i] = code;
      3'b001: for (int i = 0; i < 4; i++) if (s[i]) m_dac[i] = m_in[i];
      3'b010: begin
        for (int i = 0; i < 4; i++) if (s[i]) m_in[i] = code;
        for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
      end
      3'b011: for (int i = 0; i < 4; i++) if (s[i]) begin m_in[i] = code; m_dac[i] = code; end
      3'b100: m_pd = code[7:0];
      3'b101: model_clear();
      3'b110: m_mask = code[3:0];
      default: ;
    endcase
  endtask

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " dac"}, dac_code, exp_dac());
    chk({req, " pd_mode"}, {56'd0, pd_mode}, {56'd0, m_pd});
    chk({req, " pd_active"}, {60'd0, pd_active}, {60'd0, exp_act()});
    chk({req, " mask"}, {60'd0, ldac_mask}, {60'd0, m_mask});
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [23:0] w, input int nbits, input logic [7:0] tail);
    ser_sel_n = 1'b0;
    wait_cyc(H);
    for (int b = 0; b < nbits; b++) begin
      ser_clk = 1'b1;
      ser_din = (b < 24) ? w[23-b] : tail[7-(b-24)];
      wait_cyc(H);
      ser_clk = 1'b0;
      wait_cyc(H);
    end
    ser_clk = 1'b1;
    wait_cyc(H);
    ser_sel_n = 1'b1;
    wait_cyc(8);
    if (nbits >= 24) model_frame(w);
  endtask

  task automatic frame(input logic [2:0] cmd, input logic [2:0] adr, input logic [15:0] code);
    send({2'b00, cmd, adr, code}, 24, 8'h00);
  endtask

  task automatic pulse_ldac();
    ldac_n = 1'b0;
    wait_cyc(4);
    ldac_n = 1'b1;
    wait_cyc(6);
    for (int i = 0; i < 4; i++) if (!m_mask[i]) m_dac[i] = m_in[i];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    model_clear();
    #1 rst_n = 1'b0;
    wait_cyc(4);
    check_all("R1 in reset");
    rst_n = 1'b1;
    wait_cyc(4);
    check_all("R1 after reset");

    // R2: write and update channel 1, with the ignored top bits set
    send({2'b11, 3'b011, 3'b001, 16'hBEEF}, 24, 8'h00);
    check_all("R2 write-update ch1");

    // R3: staged write, then update
    frame(3'b000, 3'b010, 16'h1234);
    check_all("R3 staged write leaves dac");
    frame(3'b001, 3'b010, 16'hFFFF);
    check_all("R3 update copies input");

    // R4: write plus update all
    frame(3'b000, 3'b011, 16'hA0A0);
    frame(3'b010, 3'b000, 16'h5555);
    check_all("R4 write and update all");

    // R5: broadcast and unused addresses
    frame(3'b011, 3'b111, 16'h0F0F);
    check_all("R5 broadcast");
    frame(3'b011, 3'b101, 16'hDEAD);
    check_all("R5 unused address");

    // R6: early release, then a normal frame
    send({2'b00, 3'b011, 3'b011, 16'h7E57}, 23, 8'h00);
    check_all("R6 23-bit frame discarded");
    send({2'b00, 3'b100, 3'b000, 16'h00FF}, 5, 8'h00);
    check_all("R6 short frame discarded");
    frame(3'b011, 3'b011, 16'h4321);
    check_all("R6 next frame decoded");

    // R7: extra edges after the 24th
    send({2'b00, 3'b011, 3'b000, 16'h8001}, 32, 8'hFF);
    check_all("R7 trailing bits ignored");

    // R8: power-down field
    frame(3'b100, 3'b010, 16'h00E4);
    check_all("R8 power-down modes");

    // R10: mask and hardware strobe
    frame(3'b110, 3'b000, 16'h0005);
    frame(3'b000, 3'b111, 16'h7777);
    check_all("R10 mask loaded, dac held");
    pulse_ldac();
    check_all("R10 strobe on unmasked channels");

    // R11: reserved command
    frame(3'b111, 3'b111, 16'hFFFF);
    check_all("R11 reserved no effect");

    // R9: reset command
    frame(3'b101, 3'b000, 16'h1111);
    check_all("R9 reset command");
    frame(3'b001, 3'b111, 16'h0000);
    check_all("R9 inputs cleared");

    // random mix
    for (int n = 0; n < 160; n++) begin
      logic [2:0]  cmd;
      logic [2:0]  adr;
      logic [15:0] code;
      logic [1:0]  top;
      int          kind;
      int          nb;
      cmd  = 3'($urandom_range(0, 7));
      if (cmd == 3'b101 && $urandom_range(0, 3) != 0) cmd = 3'b000;
      adr  = ($urandom_range(0, 9) < 7) ? 3'($urandom_range(0, 3)) : 3'($urandom_range(4, 7));
      code = 16'($urandom);
      top  = 2'($urandom);
      kind = $urandom_range(0, 9);
      nb   = (kind == 0) ? $urandom_range(1, 23) : (kind == 1) ? $urandom_range(25, 32) : 24;
      send({top, cmd, adr, code}, nb, 8'($urandom));
      if (kind == 0)      check_all("R6 random early release");
      else if (kind == 1) check_all("R7 random trailing bits");
      else                check_all("R2 random frame");
      if ($urandom_range(0, 6) == 0) begin
        pulse_ldac();
        check_all("R10 random strobe");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule